// File: doc/BRIEF.md
# Crosspoint Lane Router with Level and Power Control

This block is the digital control core of a four-by-four single-bit crosspoint. Each of four output lanes takes its value from any one of four input lanes, and any input may feed several outputs at once. The routing, a two-bit pre-emphasis code per output and a two-bit equalization code per input come either from strap pins or from a small register file. A mode input chooses between the two sources. In register mode, separate override bits decide whether the level codes still follow the pins.

The block also derives lane power enables. The device is up when the hard power pin or the soft power bit is high. An output is enabled when the device is up and its mask bit is set. An input is enabled when an enabled output routes from it, or when the loss-of-signal monitor enable bit is set. Every output of the block is registered, so any change at the inputs or in the registers shows at the ports one clock edge later. Register writes use a simple strobe, a 2-bit address and a data word: address 0 holds the routing, 1 the output levels, 2 the input levels and 3 the control word.

Top module: `xp_core`

## Requirements
- R1: Output lane n presents the input lane chosen by its 2-bit select (00 picks input 0, 01 input 1, 10 input 2, 11 input 3). Select n sits in bits [2n+1:2n], and one input may feed any number of outputs.
- R2: With `reg_mode_i` low the selects come from `sel_pin_i`. With it high they come from the routing register (address 0).
- R3: The level codes are 00 Off, 01 Low, 10 Medium, 11 High, with lane n in bits [2n+1:2n]. From the pins, a PE pin of 1 gives 10 and an EQ pin of 1 gives 01. A pin of 0 gives 00.
- R4: The PE register (address 1) drives `pe_lvl_o` only in register mode with control bit 5 set. The EQ register (address 2) drives `eq_lvl_o` only in register mode with control bit 4 set. Otherwise the pins drive the codes and register contents have no effect.
- R5: The device is powered down only when `pwr_pin_i` is 0 and control bit 7 (soft power) is 0. While powered down, `out_en_o` is 0.
- R6: When powered up, `out_en_o[n]` equals control bit n. The control word resets to 0x0F.
- R7: `in_en_o[i]` is 1 when an enabled output selects input i, or when control bit 6 (monitor enable) is 1. This holds even while powered down.
- R8: An output lane whose enable is 0 drives 0.
- R9: Whenever `reg_mode_i` differs from its value at the previous edge, all registers return to their defaults (routing 00, levels 00, control 0x0F). This takes priority over a write in the same cycle. Writes are accepted only while `reg_mode_i` is 1.
- R10: During and after reset all outputs are 0 and all registers hold their defaults.
- R11: Every output reflects the inputs and register contents present at the previous clock edge. A select change needs exactly one edge, and no intermediate value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_mode_i | input | 1 | 0 selects pin configuration, 1 selects register configuration |
| sel_pin_i | input | 8 | Pin selects, output n in bits [2n+1:2n] |
| pe_pin_i | input | 4 | Pin pre-emphasis request per output |
| eq_pin_i | input | 4 | Pin equalization request per input |
| pwr_pin_i | input | 1 | Hard power pin, 1 = up |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Register write data |
| lane_i | input | 4 | Input lanes |
| lane_o | output | 4 | Routed output lanes |
| pe_lvl_o | output | 8 | Pre-emphasis codes per output |
| eq_lvl_o | output | 8 | Equalization codes per input |
| out_en_o | output | 4 | Output lane enables |
| in_en_o | output | 4 | Input lane enables |

## Verification
Two functions can fall in the same cycle: a register write and the clear caused by a mode change. The bench drives a routing write in the very cycle that `reg_mode_i` rises. It then judges that the routing still reads as the default, with every output fed from input 0, on the following step. A second collision pairs a write to the control word with the hard power pin going low. This shows that the soft power bit alone holds the outputs up from the next edge on. Write-only paths are observed through the lanes and enables that a write would have changed.

// File: rtl/xp_pkg.sv
package xp_pkg;

  typedef enum logic [1:0] {
    LVL_OFF  = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_MED  = 2'b10,
    LVL_HIGH = 2'b11
  } lvl_e;

  localparam logic [1:0] ADDR_ROUTE = 2'd0;
  localparam logic [1:0] ADDR_PE    = 2'd1;
  localparam logic [1:0] ADDR_EQ    = 2'd2;
  localparam logic [1:0] ADDR_CTRL  = 2'd3;

  // width of a register word: wide enough for routing, levels and control
  function automatic int data_w(input int lanes);
    int s;
    int w;
    s = $clog2(lanes);
    w = lanes * 2;
    if (lanes * s > w) w = lanes * s;
    if (lanes + 4 > w) w = lanes + 4;
    return w;
  endfunction

endpackage

// File: rtl/xp_cfg_regs.sv
module xp_cfg_regs
  import xp_pkg::*;
#(
  parameter  int LANES   = 4,
  localparam int SEL_W   = $clog2(LANES),
  localparam int ROUTE_W = LANES * SEL_W,
  localparam int LVL_W   = LANES * 2,
  localparam int CTRL_W  = LANES + 4,
  localparam int DATA_W  = data_w(LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_mode_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [ROUTE_W-1:0] route_q,
  output logic [LVL_W-1:0]   pe_q,
  output logic [LVL_W-1:0]   eq_q,
  output logic [CTRL_W-1:0]  ctrl_q
);

  localparam logic [CTRL_W-1:0] CTRL_DEF = {4'b0000, {LANES{1'b1}}};

  logic                mode_q;
  logic                mode_flip;
  logic                wr_ok;
  logic                route_en, pe_en, eq_en, ctrl_en;
  logic [ROUTE_W-1:0]  route_d;
  logic [LVL_W-1:0]    pe_d, eq_d;
  logic [CTRL_W-1:0]   ctrl_d;

  assign mode_flip = (reg_mode_i != mode_q);
  assign wr_ok     = wr_en_i && reg_mode_i && !mode_flip;

  always_comb begin
    route_en = mode_flip || (wr_ok && (wr_addr_i == ADDR_ROUTE));
    pe_en    = mode_flip || (wr_ok && (wr_addr_i == ADDR_PE));
    eq_en    = mode_flip || (wr_ok && (wr_addr_i == ADDR_EQ));
    ctrl_en  = mode_flip || (wr_ok && (wr_addr_i == ADDR_CTRL));
    if (mode_flip) begin
      route_d = '0;
      pe_d    = '0;
      eq_d    = '0;
      ctrl_d  = CTRL_DEF;
    end else begin
      route_d = wr_data_i[ROUTE_W-1:0];
      pe_d    = wr_data_i[LVL_W-1:0];
      eq_d    = wr_data_i[LVL_W-1:0];
      ctrl_d  = wr_data_i[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      route_q <= '0;
      pe_q    <= '0;
      eq_q    <= '0;
      ctrl_q  <= CTRL_DEF;
    end else begin
      mode_q <= reg_mode_i;
      if (route_en) route_q <= route_d;
      if (pe_en)    pe_q    <= pe_d;
      if (eq_en)    eq_q    <= eq_d;
      if (ctrl_en)  ctrl_q  <= ctrl_d;
    end
  end

endmodule

// File: rtl/xp_level_resolve.sv
module xp_level_resolve
  import xp_pkg::*;
#(
  parameter  int   LANES  = 4,
  parameter  lvl_e PIN_HI = LVL_MED,
  localparam int   LVL_W  = LANES * 2
) (
  input  logic             use_reg_i,
  input  logic [LANES-1:0] pin_i,
  input  logic [LVL_W-1:0] reg_lvl_i,
  output logic [LVL_W-1:0] lvl_o
);

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    lvl_e pin_code;
    assign pin_code = pin_i[n] ? PIN_HI : LVL_OFF;
    assign lvl_o[2*n +: 2] = use_reg_i ? reg_lvl_i[2*n +: 2] : pin_code;
  end

endmodule

// File: rtl/xp_power_ctrl.sv
module xp_power_ctrl #(
  parameter  int LANES = 4,
  localparam int SEL_W = $clog2(LANES),
  localparam int ROUTE_W = LANES * SEL_W
) (
  input  logic               pwr_pin_i,
  input  logic               soft_up_i,
  input  logic               los_en_i,
  input  logic [LANES-1:0]   out_mask_i,
  input  logic [ROUTE_W-1:0] sel_i,
  output logic [LANES-1:0]   out_en_o,
  output logic [LANES-1:0]   in_en_o
);

  logic up;

  assign up       = pwr_pin_i | soft_up_i;
  assign out_en_o = up ? out_mask_i : '0;

  always_comb begin
    in_en_o = '0;
    for (int i = 0; i < LANES; i++) begin
      in_en_o[i] = los_en_i;
      for (int n = 0; n < LANES; n++) begin
        if (out_en_o[n] && (sel_i[n*SEL_W +: SEL_W] == SEL_W'(i)))
          in_en_o[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/xp_route_mux.sv
module xp_route_mux #(
  parameter  int LANES = 4,
  localparam int SEL_W = $clog2(LANES),
  localparam int ROUTE_W = LANES * SEL_W
) (
  input  logic [LANES-1:0]   lane_i,
  input  logic [ROUTE_W-1:0] sel_i,
  input  logic [LANES-1:0]   out_en_i,
  output logic [LANES-1:0]   lane_o
);

  for (genvar n = 0; n < LANES; n++) begin : g_out
    assign lane_o[n] = out_en_i[n] & lane_i[sel_i[n*SEL_W +: SEL_W]];
  end

endmodule

// File: rtl/xp_core.sv
module xp_core
  import xp_pkg::*;
#(
  parameter  int LANES   = 4,
  localparam int SEL_W   = $clog2(LANES),
  localparam int ROUTE_W = LANES * SEL_W,
  localparam int LVL_W   = LANES * 2,
  localparam int CTRL_W  = LANES + 4,
  localparam int DATA_W  = data_w(LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_mode_i,
  input  logic [ROUTE_W-1:0] sel_pin_i,
  input  logic [LANES-1:0]   pe_pin_i,
  input  logic [LANES-1:0]   eq_pin_i,
  input  logic               pwr_pin_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [LANES-1:0]   lane_i,
  output logic [LANES-1:0]   lane_o,
  output logic [LVL_W-1:0]   pe_lvl_o,
  output logic [LVL_W-1:0]   eq_lvl_o,
  output logic [LANES-1:0]   out_en_o,
  output logic [LANES-1:0]   in_en_o
);

  localparam int B_IGN_EQ = LANES;
  localparam int B_IGN_PE = LANES + 1;
  localparam int B_LOS    = LANES + 2;
  localparam int B_SOFT   = LANES + 3;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q_n  <= rst_meta;
    end
  end

  logic [ROUTE_W-1:0] route_q;
  logic [LVL_W-1:0]   pe_q, eq_q;
  logic [CTRL_W-1:0]  ctrl_q;

  xp_cfg_regs #(.LANES(LANES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .reg_mode_i(reg_mode_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .route_q   (route_q),
    .pe_q      (pe_q),
    .eq_q      (eq_q),
    .ctrl_q    (ctrl_q)
  );

  logic [ROUTE_W-1:0] sel_eff;
  assign sel_eff = reg_mode_i ? route_q : sel_pin_i;

  logic [LVL_W-1:0] pe_d, eq_d;

  xp_level_resolve #(.LANES(LANES), .PIN_HI(LVL_MED)) u_pe (
    .use_reg_i(reg_mode_i & ctrl_q[B_IGN_PE]),
    .pin_i    (pe_pin_i),
    .reg_lvl_i(pe_q),
    .lvl_o    (pe_d)
  );

  xp_level_resolve #(.LANES(LANES), .PIN_HI(LVL_LOW)) u_eq (
    .use_reg_i(reg_mode_i & ctrl_q[B_IGN_EQ]),
    .pin_i    (eq_pin_i),
    .reg_lvl_i(eq_q),
    .lvl_o    (eq_d)
  );

  logic [LANES-1:0] oen_d, ien_d, lane_d;

  xp_power_ctrl #(.LANES(LANES)) u_pwr (
    .pwr_pin_i (pwr_pin_i),
    .soft_up_i (ctrl_q[B_SOFT]),
    .los_en_i  (ctrl_q[B_LOS]),
    .out_mask_i(ctrl_q[LANES-1:0]),
    .sel_i     (sel_eff),
    .out_en_o  (oen_d),
    .in_en_o   (ien_d)
  );

  xp_route_mux #(.LANES(LANES)) u_mux (
    .lane_i  (lane_i),
    .sel_i   (sel_eff),
    .out_en_i(oen_d),
    .lane_o  (lane_d)
  );

  // output stage: one register level for every port
  logic out_ce;
  assign out_ce = 1'b1;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      lane_o   <= '0;
      pe_lvl_o <= '0;
      eq_lvl_o <= '0;
      out_en_o <= '0;
      in_en_o  <= '0;
    end else if (out_ce) begin
      lane_o   <= lane_d;
      pe_lvl_o <= pe_d;
      eq_lvl_o <= eq_d;
      out_en_o <= oen_d;
      in_en_o  <= ien_d;
    end
  end

endmodule

// File: rtl/xp_core_checker.sv
module xp_core_checker #(
  parameter  int LANES   = 4,
  localparam int SEL_W   = $clog2(LANES),
  localparam int ROUTE_W = LANES * SEL_W,
  localparam int LVL_W   = LANES * 2,
  localparam int CTRL_W  = LANES + 4
) (
  input logic               clk,
  input logic               rst_q_n,
  input logic               reg_mode_i,
  input logic               pwr_pin_i,
  input logic [LANES-1:0]   pe_pin_i,
  input logic [ROUTE_W-1:0] sel_eff,
  input logic [ROUTE_W-1:0] route_q,
  input logic [CTRL_W-1:0]  ctrl_q,
  input logic [LANES-1:0]   lane_o,
  input logic [LVL_W-1:0]   pe_lvl_o,
  input logic [LANES-1:0]   out_en_o,
  input logic [LANES-1:0]   in_en_o
);

  localparam logic [CTRL_W-1:0] CTRL_DEF = {4'b0000, {LANES{1'b1}}};

  // one full cycle out of reset before any $past is trusted
  logic warm;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) warm <= 1'b0;
    else          warm <= 1'b1;
  end

  logic [ROUTE_W-1:0] sel_prev;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) sel_prev <= '0;
    else          sel_prev <= sel_eff;
  end

  logic [LVL_W-1:0] pe_pin_map;
  logic [LANES-1:0] covered;
  always_comb begin
    for (int n = 0; n < LANES; n++) begin
      pe_pin_map[2*n +: 2] = {pe_pin_i[n], 1'b0};
      covered[n] = in_en_o[sel_prev[n*SEL_W +: SEL_W]];
    end
  end

  assert_dark_lane_R8: assert property (@(posedge clk) disable iff (!warm)
    (lane_o & ~out_en_o) == '0);

  assert_power_down_R5: assert property (@(posedge clk) disable iff (!warm)
    $past(!pwr_pin_i && !ctrl_q[LANES+3]) |-> (out_en_o == '0));

  assert_out_mask_R6: assert property (@(posedge clk) disable iff (!warm)
    (out_en_o & ~$past(ctrl_q[LANES-1:0])) == '0);

  assert_los_wake_R7: assert property (@(posedge clk) disable iff (!warm)
    $past(ctrl_q[LANES+2]) |-> (&in_en_o));

  assert_fanin_on_R7: assert property (@(posedge clk) disable iff (!warm)
    (out_en_o & ~covered) == '0);

  assert_pin_pe_R3: assert property (@(posedge clk) disable iff (!warm)
    $past(!reg_mode_i) |-> (pe_lvl_o == $past(pe_pin_map)));

  assert_mode_clear_R9: assert property (@(posedge clk) disable iff (!warm)
    (reg_mode_i != $past(reg_mode_i)) |=> ((route_q == '0) && (ctrl_q == CTRL_DEF)));

endmodule

bind xp_core xp_core_checker #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .reg_mode_i(reg_mode_i),
  .pwr_pin_i (pwr_pin_i),
  .pe_pin_i  (pe_pin_i),
  .sel_eff   (sel_eff),
  .route_q   (route_q),
  .ctrl_q    (ctrl_q),
  .lane_o    (lane_o),
  .pe_lvl_o  (pe_lvl_o),
  .out_en_o  (out_en_o),
  .in_en_o   (in_en_o)
);

// File: tb/xp_core_test.sv
module xp_core_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_mode_i;
  logic [7:0] sel_pin_i;
  logic [3:0] pe_pin_i, eq_pin_i;
  logic       pwr_pin_i;
  logic       wr_en_i;
  logic [1:0] wr_addr_i;
  logic [7:0] wr_data_i;
  logic [3:0] lane_i;
  logic [3:0] lane_o;
  logic [7:0] pe_lvl_o, eq_lvl_o;
  logic [3:0] out_en_o, in_en_o;

  always #10 clk = ~clk;  // 50 MHz

  xp_core uut (.*);

  typedef struct {
    logic [3:0] lane;
    logic [7:0] pe;
    logic [7:0] eq;
    logic [3:0] oen;
    logic [3:0] ien;
    string      req;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // bench model of the register file
  logic [7:0] m_route, m_pe, m_eq, m_ctrl;
  logic       m_mode_q;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  // monitor: samples a quarter period after the rising edge
  always begin
    @(posedge clk);
    #5;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (lane_o !== e.lane || pe_lvl_o !== e.pe || eq_lvl_o !== e.eq ||
          out_en_o !== e.oen || in_en_o !== e.ien) begin
        n_bad++;
        $display("FAIL %s actual lane=%b pe=%h eq=%h oen=%b ien=%b expected lane=%b pe=%h eq=%h oen=%b ien=%b",
                 e.req, lane_o, pe_lvl_o, eq_lvl_o, out_en_o, in_en_o,
                 e.lane, e.pe, e.eq, e.oen, e.ien);
      end
    end
  end

  // driver: applies one cycle of stimulus at the falling edge and predicts
  task automatic step(input logic mode, input logic [7:0] sel, input logic [3:0] pe,
                      input logic [3:0] eq, input logic pwr, input logic we,
                      input logic [1:0] addr, input logic [7:0] data,
                      input logic [3:0] lanes, input string req);
    exp_t e;
    logic [1:0] s [4];
    logic up;
    @(negedge clk);
    reg_mode_i = mode; sel_pin_i = sel; pe_pin_i = pe; eq_pin_i = eq;
    pwr_pin_i = pwr; wr_en_i = we; wr_addr_i = addr; wr_data_i = data; lane_i = lanes;
    up = pwr | m_ctrl[7];
    e.ien = {4{m_ctrl[6]}};
    for (int n = 0; n < 4; n++) begin
      s[n] = mode ? m_route[2*n +: 2] : sel[2*n +: 2];
      e.oen[n] = up & m_ctrl[n];
      e.lane[n] = e.oen[n] & lanes[s[n]];
      e.pe[2*n +: 2] = (mode && m_ctrl[5]) ? m_pe[2*n +: 2] : (pe[n] ? 2'b10 : 2'b00);
      e.eq[2*n +: 2] = (mode && m_ctrl[4]) ? m_eq[2*n +: 2] : (eq[n] ? 2'b01 : 2'b00);
    end
    for (int n = 0; n < 4; n++) if (e.oen[n]) e.ien[s[n]] = 1'b1;
    e.req = req;
    sb.push_back(e);
    if (mode != m_mode_q) begin
      m_route = 8'h00; m_pe = 8'h00; m_eq = 8'h00; m_ctrl = 8'h0F;
    end else if (mode && we) begin
      case (addr)
        2'd0: m_route = data;
        2'd1: m_pe    = data;
        2'd2: m_eq    = data;
        default: m_ctrl = data;
      endcase
    end
    m_mode_q = mode;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_route = 8'h00; m_pe = 8'h00; m_eq = 8'h00; m_ctrl = 8'h0F; m_mode_q = 1'b0;
    rst_n = 1'b0; reg_mode_i = 1'b0; sel_pin_i = 8'h00; pe_pin_i = 4'h0; eq_pin_i = 4'h0;
    pwr_pin_i = 1'b0; wr_en_i = 1'b0; wr_addr_i = 2'd0; wr_data_i = 8'h00; lane_i = 4'hF;
    repeat (3) @(negedge clk);
    // R10: reset state observed while reset is held
    chk("R10 lanes in reset", 64'(lane_o), 64'h0);
    chk("R10 levels in reset", 64'({pe_lvl_o, eq_lvl_o}), 64'h0);
    chk("R10 enables in reset", 64'({out_en_o, in_en_o}), 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 outputs after release", 64'({lane_o, out_en_o, in_en_o}), 64'h0);

    // R1 R2 R11: pin routing, straight, crossed, broadcast
    step(0, 8'hE4, 4'h0, 4'h0, 1, 0, 0, 8'h00, 4'b1010, "R1 straight routing");
    step(0, 8'hE4, 4'h0, 4'h0, 1, 0, 0, 8'h00, 4'b0101, "R1 straight routing 2");
    step(0, 8'h1B, 4'h0, 4'h0, 1, 0, 0, 8'h00, 4'b0001, "R11 crossed routing next edge");
    step(0, 8'hAA, 4'h0, 4'h0, 1, 0, 0, 8'h00, 4'b0100, "R1 broadcast from input 2, R7 fanin");
    // R3: pin level mapping
    step(0, 8'hAA, 4'b1010, 4'b0110, 1, 0, 0, 8'h00, 4'b0100, "R3 pin level map");
    // R5: hard pin low powers down
    step(0, 8'hE4, 4'h0, 4'h0, 0, 0, 0, 8'h00, 4'hF, "R5 powered down");
    // R9: write in pin mode ignored (soft power write)
    step(0, 8'hE4, 4'h0, 4'h0, 0, 1, 3, 8'h80, 4'hF, "R9 pin mode write");
    step(0, 8'hE4, 4'h0, 4'h0, 0, 0, 0, 8'h00, 4'hF, "R9 pin mode write ignored");
    // R9: entering register mode with a same-cycle write, clear wins
    step(1, 8'hE4, 4'h0, 4'h0, 1, 1, 0, 8'h1B, 4'h1, "R2 register mode entry");
    step(1, 8'hE4, 4'h0, 4'h0, 1, 0, 0, 8'h00, 4'h1, "R9 clear beats write");
    // R2: routing from register
    step(1, 8'hE4, 4'h0, 4'h0, 1, 1, 0, 8'h1B, 4'h8, "R2 route write cycle");
    step(1, 8'hE4, 4'h0, 4'h0, 1, 0, 0, 8'h00, 4'h8, "R2 register routing");
    // R4: overrides
    step(1, 8'hE4, 4'hF, 4'hF, 1, 1, 3, 8'h3F, 4'h8, "R4 before override");
    step(1, 8'hE4, 4'hF, 4'hF, 1, 1, 1, 8'hE4, 4'h8, "R4 override, pins high");
    step(1, 8'hE4, 4'hF, 4'hF, 1, 1, 2, 8'h1B, 4'h8, "R4 PE from register");
    step(1, 8'hE4, 4'h0, 4'h0, 1, 0, 0, 8'h00, 4'h8, "R4 EQ from register, pins ignored");
    // R6 R7 R8: output mask and derived input enables
    step(1, 8'hE4, 4'h0, 4'h0, 1, 1, 3, 8'h05, 4'hF, "R4 override still set");
    step(1, 8'hE4, 4'h5, 4'hA, 1, 0, 0, 8'h00, 4'hF, "R6 mask, R7 used inputs, R8 dark lanes, R4 pins back");
    // R5: soft power with hard pin low, written in same cycle as pin drop
    step(1, 8'hE4, 4'h0, 4'h0, 0, 1, 3, 8'h85, 4'hF, "R5 pin low soft off");
    step(1, 8'hE4, 4'h0, 4'h0, 0, 0, 0, 8'h00, 4'hF, "R5 soft power holds up");
    // R7: monitor enable while powered down
    step(1, 8'hE4, 4'h0, 4'h0, 0, 1, 3, 8'h40, 4'hF, "R5 soft up before clearing");
    step(1, 8'hE4, 4'h0, 4'h0, 0, 0, 0, 8'h00, 4'hF, "R7 monitor enable while down");
    // R9: leaving register mode clears control
    step(0, 8'hE4, 4'h0, 4'h0, 0, 0, 0, 8'h00, 4'hF, "R9 mode exit");
    step(0, 8'hE4, 4'h0, 4'h0, 0, 0, 0, 8'h00, 4'hF, "R9 control cleared on exit");
    step(0, 8'h00, 4'h0, 4'h0, 1, 0, 0, 8'h00, 4'h1, "R1 broadcast from input 0");
    step(0, 8'h00, 4'h0, 4'h0, 1, 0, 0, 8'h00, 4'h0, "R1 broadcast low");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule